// File: doc/BRIEF.md
# Counted Edge/Level Interrupt Input Stage

This block is the front end of an interrupt controller with sixteen request lines, grouped as two banks of eight (bank = line bit 3, bit within the bank = line bits 2:0). Sources do not drive a wire level. Instead they send events on a single event port: assert, deassert or pulse. Each line keeps a small signed counter of outstanding asserts, so several sources can share one line.

Each bank has a trigger-mode register that selects edge or level mode per line. The stage uses the counter and the mode to decide when to set the line's request bit. It exposes per-line activity (counter above zero) so that the controller can decide whether to clear a request on acknowledge. The controller clears requests through a per-line clear input. Events for a bank whose controller is not yet initialised are dropped. Line numbers above 15 are rejected.

Top module: `irq_input_stage`

## Requirements
- R1: After reset, all request bits, active flags and negative flags are 0, both trigger-mode registers read 0 (all lines edge mode), evt_ready_o is 1 and evt_reject_o is 0.
- R2: An accepted assert event (evt_kind_i = 0) increments the line's counter and a deassert event (evt_kind_i = 1) decrements it; active_o[line] is 1 exactly while the counter is above zero. Kind 3 has no effect. State changes appear after the accepting clock edge.
- R3: In edge mode (mode bit 0), a counter step from 0 to 1 sets the request bit; any other step in edge mode leaves the request bit unchanged.
- R4: In level mode (mode bit 1), any assert or deassert step that leaves the counter above zero sets the request bit.
- R5: A counter step from 1 to 0 does not clear the request bit. req_clr_i[n] clears request bit n at the next edge, and a set in the same cycle takes priority over the clear.
- R6: neg_o[line] is 1 while the line's counter is negative.
- R7: Counters are 4-bit signed and saturate: an assert at +7 stays at +7, and a deassert at -8 stays at -8.
- R8: A pulse (evt_kind_i = 2) applies an assert step at the accepting edge and a deassert step at the next edge. evt_ready_o is 0 for the cycle between those two edges, and an event is accepted only when evt_valid_i and evt_ready_o are both 1.
- R9: A write with cfg_sel_i = 0 stores cfg_wdata_i AND 0xF8 as the mode register of bank 0, so lines 0, 1 and 2 stay edge mode. cfg_rdata_o returns the stored value of the bank chosen by cfg_sel_i.
- R10: A write with cfg_sel_i = 1 stores cfg_wdata_i AND 0xDE as the mode register of bank 1, so lines 8 and 13 stay edge mode.
- R11: An event for a line whose bank has bank_ready_i low is accepted but changes no counter or request. A pulse on such a bank does not drop evt_ready_o. The second step of a pulse is dropped if its bank is not ready at that edge.
- R12: An accepted event with evt_line_i of 16 or more changes no state, and evt_reject_o is 1 for the cycle after its accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | Event offered |
| evt_ready_o | output | 1 | Event port can accept |
| evt_line_i | input | 5 | Target line number |
| evt_kind_i | input | 2 | 0 assert, 1 deassert, 2 pulse, 3 none |
| bank_ready_i | input | 2 | Per-bank controller initialised |
| evt_reject_o | output | 1 | Previous accepted event had an out-of-range line |
| req_clr_i | input | 16 | Per-line request clear |
| req_o | output | 16 | Per-line request bits |
| active_o | output | 16 | Counter above zero |
| neg_o | output | 16 | Counter negative |
| cfg_we_i | input | 1 | Trigger-mode register write |
| cfg_sel_i | input | 1 | Bank select for write and read |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Selected trigger-mode register |

## Verification
A wrong counter value does not show at once. It appears on active_o or neg_o only when the counter crosses zero, and on req_o only at a later 0-to-1 step or a level-mode step. The saturation and negative cases are therefore driven deep on both sides and then walked back across zero. A wrong mode bit shows only at the next step on that line, so masked lines are exercised both before and after a clear. Every output is compared with a behavioural model each cycle, so a divergence is caught on the first edge at which it becomes visible.

// File: rtl/irq_in_pkg.sv
package irq_in_pkg;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned BANK_W    = 8;
  localparam int unsigned NUM_LINES = NUM_BANKS * BANK_W;
  localparam int unsigned LIDX_W    = $clog2(NUM_LINES);
  localparam int unsigned BSEL_W    = $clog2(NUM_BANKS);
  localparam int unsigned BBIT_W    = $clog2(BANK_W);

  typedef enum logic [1:0] {
    EVT_ASSERT   = 2'd0,
    EVT_DEASSERT = 2'd1,
    EVT_PULSE    = 2'd2,
    EVT_NONE     = 2'd3
  } evt_kind_e;

  // lines that are wired to edge mode regardless of writes
  function automatic logic [BANK_W-1:0] lvl_wmask(int unsigned bank);
    case (bank)
      0:       lvl_wmask = 8'hF8;
      1:       lvl_wmask = 8'hDE;
      default: lvl_wmask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
  import irq_in_pkg::*;
#(
  parameter int unsigned LINE_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 evt_valid_i,
  output logic                 evt_ready_o,
  input  logic [LINE_W-1:0]    evt_line_i,
  input  logic [1:0]           evt_kind_i,
  input  logic [NUM_BANKS-1:0] bank_ready_i,
  output logic                 evt_reject_o,
  output logic [NUM_LINES-1:0] step_inc_o,
  output logic [NUM_LINES-1:0] step_dec_o
);
  logic              pend_q;
  logic [LIDX_W-1:0] pline_q;
  logic              reject_q;
  logic              acc;
  logic              in_range;
  logic [LIDX_W-1:0] lidx;
  logic              bank_ok;
  logic              pbank_ok;
  evt_kind_e         kind;

  assign kind     = evt_kind_e'(evt_kind_i);
  assign evt_ready_o = ~pend_q;
  assign acc      = evt_valid_i & evt_ready_o;
  assign in_range = (evt_line_i < LINE_W'(NUM_LINES));
  assign lidx     = evt_line_i[LIDX_W-1:0];
  assign bank_ok  = bank_ready_i[lidx[LIDX_W-1:BBIT_W]];
  assign pbank_ok = bank_ready_i[pline_q[LIDX_W-1:BBIT_W]];

  always_comb begin
    step_inc_o = '0;
    step_dec_o = '0;
    if (pend_q) begin
      if (pbank_ok) step_dec_o[pline_q] = 1'b1;
    end else if (acc && in_range && bank_ok) begin
      case (kind)
        EVT_ASSERT, EVT_PULSE: step_inc_o[lidx] = 1'b1;
        EVT_DEASSERT:          step_dec_o[lidx] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      pline_q  <= '0;
      reject_q <= 1'b0;
    end else begin
      reject_q <= acc & ~in_range;
      pend_q   <= acc & in_range & bank_ok & (kind == EVT_PULSE);
      if (acc && in_range) pline_q <= lidx;
    end
  end

  assign evt_reject_o = reject_q;

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(step_inc_o | step_dec_o)); // R2
  AST_REJECT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !in_range) |=> (evt_reject_o && evt_ready_o)); // R12
  AST_PULSE_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_range && bank_ok && kind == EVT_PULSE) |=> !evt_ready_o ##1 evt_ready_o); // R8
endmodule

// File: rtl/irq_trig_regs.sv
module irq_trig_regs
  import irq_in_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [BSEL_W-1:0]    cfg_sel_i,
  input  logic [BANK_W-1:0]    cfg_wdata_i,
  output logic [BANK_W-1:0]    cfg_rdata_o,
  output logic [NUM_LINES-1:0] level_o
);
  logic [NUM_BANKS-1:0][BANK_W-1:0] mode_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] WMASK = lvl_wmask(b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mode_q[b] <= '0;
      else if (cfg_we_i && cfg_sel_i == BSEL_W'(b))
        mode_q[b] <= cfg_wdata_i & WMASK;
    end
    assign level_o[b*BANK_W +: BANK_W] = mode_q[b];

    AST_FIXED_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_sel_i == BSEL_W'(b)) |=> ((level_o[b*BANK_W +: BANK_W] & ~WMASK) == '0)); // R9 R10
  end

  assign cfg_rdata_o = mode_q[cfg_sel_i];

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(level_o)); // R9
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  input  logic level_i,
  input  logic clr_i,
  output logic req_o,
  output logic active_o,
  output logic neg_o
);
  localparam logic signed [CNT_W-1:0] ZERO = '0;
  localparam logic signed [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic signed [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};

  logic signed [CNT_W-1:0] cnt_q, cnt_d;
  logic req_q, set;

  always_comb begin
    cnt_d = cnt_q;
    set   = 1'b0;
    if (inc_i) begin
      cnt_d = (cnt_q == CMAX) ? cnt_q : cnt_q + ONE;
      set   = (cnt_q == ZERO && cnt_d == ONE) || (level_i && cnt_d > ZERO);
    end else if (dec_i) begin
      cnt_d = (cnt_q == CMIN) ? cnt_q : cnt_q - ONE;
      set   = level_i && cnt_d > ZERO;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= ZERO;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (set)        req_q <= 1'b1;
      else if (clr_i) req_q <= 1'b0;
    end
  end

  assign req_o    = req_q;
  assign active_o = cnt_q > ZERO;
  assign neg_o    = cnt_q[CNT_W-1];

  AST_EDGE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !active_o && !neg_o) |=> (req_o && active_o)); // R3
  AST_FALL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && req_o && !clr_i) |=> req_o); // R5
  AST_SAT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q == CMAX) |=> (cnt_q == CMAX)); // R7
  AST_SAT_BOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && cnt_q == CMIN) |=> (cnt_q == CMIN)); // R7
  AST_LEVEL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((inc_i || dec_i) && level_i) |=> (req_o || !active_o)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !dec_i) |=> ($stable(active_o) && $stable(neg_o))); // R2
endmodule

// File: rtl/irq_input_stage.sv
module irq_input_stage
  import irq_in_pkg::*;
#(
  parameter int unsigned LINE_W = 5,
  parameter int unsigned CNT_W  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 evt_valid_i,
  output logic                 evt_ready_o,
  input  logic [LINE_W-1:0]    evt_line_i,
  input  logic [1:0]           evt_kind_i,
  input  logic [NUM_BANKS-1:0] bank_ready_i,
  output logic                 evt_reject_o,
  input  logic [NUM_LINES-1:0] req_clr_i,
  output logic [NUM_LINES-1:0] req_o,
  output logic [NUM_LINES-1:0] active_o,
  output logic [NUM_LINES-1:0] neg_o,
  input  logic                 cfg_we_i,
  input  logic [BSEL_W-1:0]    cfg_sel_i,
  input  logic [BANK_W-1:0]    cfg_wdata_i,
  output logic [BANK_W-1:0]    cfg_rdata_o
);
  logic [NUM_LINES-1:0] step_inc, step_dec, level;

  irq_evt_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_valid_i  (evt_valid_i),
    .evt_ready_o  (evt_ready_o),
    .evt_line_i   (evt_line_i),
    .evt_kind_i   (evt_kind_i),
    .bank_ready_i (bank_ready_i),
    .evt_reject_o (evt_reject_o),
    .step_inc_o   (step_inc),
    .step_dec_o   (step_dec)
  );

  irq_trig_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .level_o     (level)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    irq_line_cell #(.CNT_W(CNT_W)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (step_inc[n]),
      .dec_i    (step_dec[n]),
      .level_i  (level[n]),
      .clr_i    (req_clr_i[n]),
      .req_o    (req_o[n]),
      .active_o (active_o[n]),
      .neg_o    (neg_o[n])
    );
  end

  AST_NO_ACT_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o & neg_o) == '0); // R6
  AST_BANK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_ready_o && bank_ready_i == '0) |=> $stable(active_o)); // R11
  AST_REJECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_ready_o && evt_line_i >= LINE_W'(NUM_LINES))
      |=> ($stable(active_o) && $stable(neg_o))); // R12
endmodule

// File: tb/irq_input_stage_tb.sv
module irq_input_stage_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_valid_i = 1'b0;
  logic        evt_ready_o;
  logic [4:0]  evt_line_i = '0;
  logic [1:0]  evt_kind_i = '0;
  logic [1:0]  bank_ready_i = 2'b11;
  logic        evt_reject_o;
  logic [15:0] req_clr_i = '0;
  logic [15:0] req_o, active_o, neg_o;
  logic        cfg_we_i = 1'b0;
  logic        cfg_sel_i = 1'b0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  irq_input_stage u_dut (.*);

  // behavioural reference model
  int m_cnt[16];
  bit m_req[16];
  bit m_set[16];
  bit [7:0] m_mode[2];
  bit m_pend;
  int m_pl;
  bit m_rej;

  function automatic void m_step(int l, bit up);
    int o = m_cnt[l];
    int n;
    bit lvl = m_mode[l/8][l%8];
    if (up) n = (o == 7) ? 7 : o + 1;
    else    n = (o == -8) ? -8 : o - 1;
    m_cnt[l] = n;
    if ((up && o == 0 && n == 1) || (lvl && n > 0)) m_set[l] = 1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) begin m_cnt[i] = 0; m_req[i] = 0; end
      m_mode[0] = 0; m_mode[1] = 0; m_pend = 0; m_pl = 0; m_rej = 0;
    end else begin
      for (int i = 0; i < 16; i++) m_set[i] = 0;
      m_rej = 0;
      if (m_pend) begin
        m_pend = 0;
        if (bank_ready_i[m_pl/8]) m_step(m_pl, 0);
      end else if (evt_valid_i) begin
        if (evt_line_i >= 16) m_rej = 1;
        else if (bank_ready_i[evt_line_i/8]) begin
          case (evt_kind_i)
            2'd0: m_step(int'(evt_line_i), 1);
            2'd1: m_step(int'(evt_line_i), 0);
            2'd2: begin m_step(int'(evt_line_i), 1); m_pend = 1; m_pl = int'(evt_line_i); end
            default: ;
          endcase
        end
      end
      for (int i = 0; i < 16; i++)
        if (m_set[i]) m_req[i] = 1; else if (req_clr_i[i]) m_req[i] = 0;
      if (cfg_we_i) m_mode[cfg_sel_i] = cfg_wdata_i & (cfg_sel_i ? 8'hDE : 8'hF8);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, after the edge has settled
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && !done) begin
      logic [15:0] er, ea, en;
      for (int i = 0; i < 16; i++) begin
        er[i] = m_req[i]; ea[i] = m_cnt[i] > 0; en[i] = m_cnt[i] < 0;
      end
      chk("R3 R4 R5 model req_o", 32'(req_o), 32'(er));
      chk("R2 R7 model active_o", 32'(active_o), 32'(ea));
      chk("R6 R7 model neg_o", 32'(neg_o), 32'(en));
      chk("R8 model evt_ready_o", 32'(evt_ready_o), 32'(!m_pend));
      chk("R12 model evt_reject_o", 32'(evt_reject_o), 32'(m_rej));
      chk("R9 R10 model cfg_rdata_o", 32'(cfg_rdata_o), 32'(m_mode[cfg_sel_i]));
    end
  end

  task automatic evt(int line, int kind);
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_line_i = 5'(line); evt_kind_i = 2'(kind);
    while (!evt_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    evt_valid_i = 1'b0;
  endtask

  task automatic clr(int line);
    @(negedge clk_i); req_clr_i = 16'(1) << line;
    @(negedge clk_i); req_clr_i = '0;
  endtask

  task automatic cfg_wr(bit sel, logic [7:0] d);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic summary();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 req_o", 32'(req_o), 0);
    chk("R1 active_o", 32'(active_o), 0);
    chk("R1 evt_ready_o", 32'(evt_ready_o), 1);
    chk("R1 cfg bank0", 32'(cfg_rdata_o), 0);
    cfg_sel_i = 1'b1; @(negedge clk_i);
    chk("R1 cfg bank1", 32'(cfg_rdata_o), 0);
    cfg_sel_i = 1'b0;

    evt(3, 0);
    chk("R3 edge 0->1 sets", 32'(req_o[3]), 1);
    chk("R2 active after assert", 32'(active_o[3]), 1);
    clr(3);
    chk("R5 clear drops req", 32'(req_o[3]), 0);
    evt(3, 0);
    chk("R3 edge 1->2 no set", 32'(req_o[3]), 0);
    evt(3, 3);
    chk("R2 kind 3 no effect", 32'(active_o[3]), 1);
    evt(3, 1); evt(3, 1);
    chk("R2 deasserts to zero", 32'(active_o[3]), 0);

    evt(2, 0); evt(2, 1);
    chk("R5 1->0 keeps req", 32'(req_o[2]), 1);

    evt(4, 1);
    chk("R6 negative flag", 32'(neg_o[4]), 1);
    evt(4, 0);
    chk("R6 neg clears at 0", 32'(neg_o[4]), 0);
    chk("R3 -1->0 no set", 32'(req_o[4]), 0);

    cfg_wr(0, 8'hFF);
    chk("R9 bank0 masked", 32'(cfg_rdata_o), 32'h F8);
    cfg_wr(1, 8'hFF);
    chk("R10 bank1 masked", 32'(cfg_rdata_o), 32'h DE);
    cfg_sel_i = 1'b0;

    evt(5, 0); clr(5); evt(5, 0);
    chk("R4 level reassert sets", 32'(req_o[5]), 1);
    clr(5); evt(5, 1);
    chk("R4 level 2->1 sets", 32'(req_o[5]), 1);

    evt(1, 0); clr(1); evt(1, 0);
    chk("R9 line1 stays edge", 32'(req_o[1]), 0);
    evt(13, 0); clr(13); evt(13, 0);
    chk("R10 line13 stays edge", 32'(req_o[13]), 0);
    evt(9, 0); clr(9); evt(9, 0);
    chk("R10 line9 level", 32'(req_o[9]), 1);

    evt(6, 2);
    chk("R8 ready low mid pulse", 32'(evt_ready_o), 0);
    @(negedge clk_i);
    chk("R8 ready back", 32'(evt_ready_o), 1);
    chk("R8 pulse net zero", 32'(active_o[6]), 0);
    chk("R8 pulse sets req", 32'(req_o[6]), 1);

    for (int i = 0; i < 9; i++) evt(10, 0);
    for (int i = 0; i < 8; i++) evt(10, 1);
    chk("R7 saturate top", 32'(neg_o[10]), 1);
    for (int i = 0; i < 10; i++) evt(11, 1);
    for (int i = 0; i < 8; i++) evt(11, 0);
    chk("R7 saturate bottom neg", 32'(neg_o[11]), 0);
    chk("R7 saturate bottom act", 32'(active_o[11]), 0);

    bank_ready_i = 2'b01;
    evt(12, 0);
    chk("R11 bank not ready", 32'(active_o[12]), 0);
    evt(12, 2);
    chk("R11 no ready drop", 32'(evt_ready_o), 1);
    @(negedge clk_i); bank_ready_i = 2'b11;

    evt(20, 0);
    chk("R12 reject pulse", 32'(evt_reject_o), 1);
    chk("R12 no alias effect", 32'(active_o[4]), 0);
    @(negedge clk_i);
    chk("R12 reject one cycle", 32'(evt_reject_o), 0);

    for (int c = 0; c < 3000; c++) begin
      @(negedge clk_i);
      evt_valid_i  = 1'($urandom % 2);
      evt_line_i   = 5'($urandom % 18);
      evt_kind_i   = 2'($urandom % 4);
      req_clr_i    = ($urandom % 6 == 0) ? 16'($urandom) : '0;
      cfg_we_i     = ($urandom % 20 == 0);
      cfg_sel_i    = 1'($urandom % 2);
      cfg_wdata_i  = 8'($urandom);
      bank_ready_i = ($urandom % 25 == 0) ? 2'($urandom) : 2'b11;
    end
    @(negedge clk_i);
    evt_valid_i = 1'b0; cfg_we_i = 1'b0; req_clr_i = '0;
    repeat (3) @(negedge clk_i);
    summary();
  end
endmodule